// File: doc/BRIEF.md
# Selectable-Rate Input Noise Filter

This block cleans up a slow external request line before it reaches an interrupt controller. The raw, asynchronous pin passes through a synchroniser. It is then sampled only on a sample tick chosen by software. The filtered level moves to a new value only when three consecutive samples agree on it. A glitch that covers no more than two sample ticks therefore never reaches the output. A rising edge of the filtered level raises a one-cycle request pulse and sets a sticky request flag, which software clears with a strobe.

Software picks the sample tick through a 3-bit rate field in an 8-bit control register. There are two sources. Five codes take taps of a free-running 10-bit divider of the block clock, and one code samples on every clock; all six depend on a divider-enable input. The last valid code uses a slow tick that arrives from outside. One code is invalid, and a write of that code is dropped. After the rate changes, the filter spends three sample ticks refilling its sample history. A settling output is high for that whole time, and the filtered level does not move during it.

Top module: `glitch_rate_filter`

## Requirements
- R1: After reset, rd_data reads 0x00, and filt_level, req_pulse, req_flag and settling are all low.
- R2: A write whose low three bits are 3'b110 is dropped. The rate field keeps its previous value and settling does not rise.
- R3: The rate field is rd_data[2:0]. Rate codes select these ticks: 0 is every clock; 1 to 5 tick on the cycles when the low (code+5) bits of the 10-bit divider are all ones (clock/64 up to clock/1024); 7 uses lf_tick.
- R4: Bits 7:3 of the control register always read zero, and writes to them have no effect.
- R5: filt_level takes a new value only on a sample tick where that tick's sample and the two samples before it all equal that new value. A pulse that spans at most two ticks is rejected.
- R6: A write of a valid code that differs from the current field raises settling from the next cycle. Settling stays high until three sample ticks have passed, and filt_level holds during that time. Rewriting the current code has no effect.
- R7: With div_en low, codes 0 to 5 produce no sample ticks and the divider stops. Code 7 keeps sampling on lf_tick.
- R8: req_pulse is high for exactly the first cycle in which filt_level reads high after reading low.
- R9: req_flag becomes high in the cycle after req_pulse and stays high until the cycle after req_clr. When req_clr and req_pulse coincide, the flag ends up set.
- R10: The pin goes through two synchroniser flops. With code 0, a level held from one cycle's start reaches filt_level after exactly five clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| div_en | input | 1 | Runs the divider and enables the clock-derived rates |
| lf_tick | input | 1 | One-cycle slow tick, synchronous to clk |
| pin_async | input | 1 | Raw external request pin |
| req_clr | input | 1 | Clears the sticky request flag |
| filt_level | output | 1 | Filtered pin level |
| req_pulse | output | 1 | One-cycle pulse on a filtered rising edge |
| req_flag | output | 1 | Sticky request flag |
| settling | output | 1 | Filter is refilling after a rate change |

## Verification
The hardest situation to reach is settling at a slow rate. The three reinitialising ticks then span thousands of cycles, and their phase depends on a divider that software cannot see. The stimulus switches to the /1024 and slow-tick rates and times the whole settling window against the bounds that the divider phase allows. It also stops the divider while a clock-derived rate is pending, which leaves settling stuck high until the divider runs again. A behavioural model tracks the divider and the sample queue, so every cycle of these windows is compared.

// File: rtl/gf_pkg.sv
package gf_pkg;
    localparam int REG_W      = 8;
    localparam int SEL_W      = 3;
    localparam int TAP_CODES  = 6;       // codes 0..5 come from the divider
    localparam int TAP_BASE   = 5;       // code c (c>0) uses c+TAP_BASE bits
    localparam int DIV_W      = TAP_CODES - 1 + TAP_BASE;
    localparam int VOTES      = 3;
    localparam int SETTLE     = 3;
    localparam logic [SEL_W-1:0] CODE_BAD = 3'b110;
    localparam logic [SEL_W-1:0] CODE_LF  = 3'b111;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             lvl_prev;
        logic             flag;
    } ctl_state_t;
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gf_tick_gen.sv
module gf_tick_gen
    import gf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_en,
    input  logic             lf_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0]     cnt_d, cnt_q;
    logic [TAP_CODES-1:0] hit;

    always_comb begin
        cnt_d = div_en ? cnt_q + 1'b1 : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar c = 0; c < TAP_CODES; c++) begin : g_tap
        if (c == 0) begin : g_every
            assign hit[c] = div_en;
        end else begin : g_div
            assign hit[c] = div_en & (&cnt_q[c+TAP_BASE-1:0]);
        end
    end

    always_comb begin
        tick = 1'b0;
        if (sel == CODE_LF) begin
            tick = lf_tick;
        end else begin
            for (int c = 0; c < TAP_CODES; c++) begin
                if (sel == SEL_W'(c)) tick = hit[c];
            end
        end
    end
endmodule

// File: rtl/gf_vote.sv
module gf_vote #(
    parameter int VOTES  = 3,
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    input  logic restart,
    output logic level,
    output logic settling
);
    localparam int HIST_W = VOTES - 1;
    localparam int CNT_W  = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
        logic              lvl;
    } vote_state_t;

    vote_state_t st_d, st_q;
    logic [VOTES-1:0] window;

    always_comb begin
        st_d   = st_q;
        window = {st_q.hist, sample};
        if (tick) begin
            st_d.hist = window[HIST_W-1:0];
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if (&window) begin
                st_d.lvl = 1'b1;
            end else if (~|window) begin
                st_d.lvl = 1'b0;
            end
        end
        if (restart) st_d.cnt = CNT_W'(SETTLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.lvl;
    assign settling = (st_q.cnt != '0);
endmodule

// File: rtl/glitch_rate_filter.sv
module glitch_rate_filter
    import gf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       div_en,
    input  logic       lf_tick,
    input  logic       pin_async,
    input  logic       req_clr,
    output logic       filt_level,
    output logic       req_pulse,
    output logic       req_flag,
    output logic       settling
);
    ctl_state_t st_d, st_q;
    logic pin_sync;
    logic sample_tick;
    logic restart;
    logic lvl;
    logic rise;

    gf_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_async),
        .q_out (pin_sync)
    );

    gf_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_en  (div_en),
        .lf_tick (lf_tick),
        .sel     (st_q.sel),
        .tick    (sample_tick)
    );

    gf_vote #(.VOTES(VOTES), .SETTLE(SETTLE)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .sample   (pin_sync),
        .restart  (restart),
        .level    (lvl),
        .settling (settling)
    );

    assign rise = lvl & ~st_q.lvl_prev;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (wr_en && wr_data[SEL_W-1:0] != CODE_BAD
                  && wr_data[SEL_W-1:0] != st_q.sel) begin
            st_d.sel = wr_data[SEL_W-1:0];
            restart  = 1'b1;
        end
        st_d.lvl_prev = lvl;
        st_d.flag     = (st_q.flag & ~req_clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = {{(REG_W-SEL_W){1'b0}}, st_q.sel};
    assign filt_level = lvl;
    assign req_pulse  = rise;
    assign req_flag   = st_q.flag;
endmodule

// File: rtl/gf_checker.sv
module gf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       div_en,
    input logic       req_clr,
    input logic       filt_level,
    input logic       req_pulse,
    input logic       req_flag,
    input logic       settling,
    input logic       sample_tick
);
    a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:3] == 5'd0);

    a_r2_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2:0] != 3'b110);

    a_r6_level_holds_settling: assert property (@(posedge clk) disable iff (!rst_n)
        settling |=> $stable(filt_level));

    a_r5_level_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_level) |-> $past(sample_tick));

    a_r7_no_tick_div_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_en && rd_data[2:0] != 3'b111) |-> !sample_tick);

    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |-> $rose(filt_level));

    a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |=> req_flag);

    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        req_clr |=> (req_flag == $past(req_pulse)));
endmodule

bind glitch_rate_filter gf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .div_en      (div_en),
    .req_clr     (req_clr),
    .filt_level  (filt_level),
    .req_pulse   (req_pulse),
    .req_flag    (req_flag),
    .settling    (settling),
    .sample_tick (sample_tick)
);

// File: tb/sim_glitch_rate_filter.sv
module sim_glitch_rate_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       div_en = 1'b1;
    logic       lf_tick = 1'b0;
    logic       pin_async = 1'b0;
    logic       req_clr = 1'b0;
    logic       filt_level, req_pulse, req_flag, settling;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit lf_on = 0;
    int lf_cnt = 0;

    always #2.5 clk = ~clk;

    glitch_rate_filter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .div_en(div_en), .lf_tick(lf_tick),
        .pin_async(pin_async), .req_clr(req_clr), .filt_level(filt_level),
        .req_pulse(req_pulse), .req_flag(req_flag), .settling(settling)
    );

    // ---------------- behavioural reference model ----------------
    int m_sel = 0, m_div = 0, m_settle = 0;
    int m_p1 = 0, m_p2 = 0;
    int m_lvl = 0, m_prev = 0, m_flag = 0;
    int m_samp[$];

    function automatic bit m_tick();
        int bits;
        if (m_sel == 7) return lf_tick;
        if (m_sel == 0) return div_en;
        bits = m_sel + 5;
        return div_en && ((m_div % (1 << bits)) == (1 << bits) - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_div = 0; m_settle = 0; m_p1 = 0; m_p2 = 0;
            m_lvl = 0; m_prev = 0; m_flag = 0;
            m_samp = '{0, 0};
        end else begin
            bit t;
            int pulse, old_p2;
            t      = m_tick();
            pulse  = m_lvl && !m_prev;
            old_p2 = m_p2;
            m_flag = (m_flag && !req_clr) || pulse;
            m_prev = m_lvl;
            if (t) begin
                m_samp.push_back(old_p2);
                if (m_samp.size() > 3) void'(m_samp.pop_front());
                if (m_settle > 0) m_settle--;
                else if (m_samp[0] == m_samp[1] && m_samp[1] == m_samp[2])
                    m_lvl = m_samp[2];
            end
            if (wr_en && wr_data[2:0] != 3'b110 && int'(wr_data[2:0]) != m_sel) begin
                m_sel    = wr_data[2:0];
                m_settle = 3;
            end
            m_p2 = m_p1;
            m_p1 = pin_async;
            if (div_en) m_div = (m_div + 1) % 1024;
        end
    end

    task automatic cmp(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R5 filt_level", filt_level, m_lvl);
            cmp("R8 req_pulse", req_pulse, m_lvl && !m_prev);
            cmp("R9 req_flag", req_flag, m_flag);
            cmp("R6 settling", settling, m_settle != 0);
            cmp("R4 rd_data", rd_data, m_sel);
        end
    end

    // slow tick source
    always @(negedge clk) begin
        if (lf_on) begin
            lf_cnt++;
            lf_tick <= (lf_cnt % 40 == 0);
        end else begin
            lf_tick <= 1'b0;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_pin(int width, int gap);
        @(negedge clk); pin_async = 1'b1;
        cyc(width);
        pin_async = 1'b0;
        cyc(gap);
    endtask

    task automatic clear_flag();
        @(negedge clk); req_clr = 1'b1;
        @(negedge clk); req_clr = 1'b0;
    endtask

    task automatic settle_len(output int n);
        n = 0;
        while (settling && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int n;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        cmp("R1 rd_data", rd_data, 0);
        cmp("R1 filt_level", filt_level, 0);
        cmp("R1 req_flag", req_flag, 0);
        cmp("R1 req_pulse", req_pulse, 0);
        cmp("R1 settling", settling, 0);

        // R10 latency: two sync flops then three agreeing samples
        @(negedge clk); pin_async = 1'b1;
        cyc(4);
        cmp("R10 level after 4 edges", filt_level, 0);
        cyc(1);
        cmp("R10 level after 5 edges", filt_level, 1);
        cmp("R8 pulse first high cycle", req_pulse, 1);
        cyc(1);
        cmp("R8 pulse one cycle", req_pulse, 0);
        cmp("R9 flag set", req_flag, 1);
        pin_async = 1'b0;
        cyc(10);
        clear_flag();
        cmp("R9 flag cleared", req_flag, 0);

        // R5 glitches at the every-clock rate
        pulse_pin(1, 10);
        cmp("R5 1-sample glitch rejected", req_flag, 0);
        pulse_pin(2, 10);
        cmp("R5 2-sample glitch rejected", req_flag, 0);
        pulse_pin(3, 10);
        cmp("R5 3-sample pulse passes", req_flag, 1);

        // R9 set wins over clear
        @(negedge clk); pin_async = 1'b1;
        while (!req_pulse) @(negedge clk);
        req_clr = 1'b1;
        @(negedge clk); req_clr = 1'b0;
        cmp("R9 set wins", req_flag, 1);
        pin_async = 1'b0;
        cyc(10);
        clear_flag();

        // R4 upper bits ignored, R3/R6 /64 settling window
        write_reg(8'hF9);
        cmp("R4 upper bits dropped", rd_data, 8'h01);
        settle_len(n);
        cmp("R3 /64 settle in range", (n >= 128 && n <= 192), 1);
        write_reg(8'h01);
        cmp("R6 same code no settle", settling, 0);

        // R2 prohibited code
        write_reg(8'h06);
        cmp("R2 code dropped", rd_data, 8'h01);
        cmp("R2 no settle", settling, 0);

        // R5 at /64: two periods rejected, three pass
        pulse_pin(128, 300);
        cmp("R5 2-period pulse rejected", filt_level, 0);
        @(negedge clk); pin_async = 1'b1;
        cyc(200);
        cmp("R5 3-period pulse passes", filt_level, 1);
        pin_async = 1'b0;
        cyc(300);
        cmp("R5 returns low", filt_level, 0);

        // R3 /1024 settling
        write_reg(8'h05);
        settle_len(n);
        cmp("R3 /1024 settle in range", (n >= 2048 && n <= 3072), 1);

        // R7 slow tick with divider stopped
        @(negedge clk); div_en = 1'b0; lf_on = 1;
        write_reg(8'h07);
        settle_len(n);
        cmp("R7 slow-tick settle in range", (n >= 80 && n <= 120), 1);
        @(negedge clk); pin_async = 1'b1;
        cyc(160);
        cmp("R7 slow-tick sampling", filt_level, 1);
        write_reg(8'h00);
        cyc(50);
        cmp("R7 stalled settle with divider off", settling, 1);
        cmp("R7 level frozen", filt_level, 1);
        @(negedge clk); div_en = 1'b1;
        cyc(10);
        cmp("R7 settle ends with divider on", settling, 0);
        pin_async = 1'b0;
        cyc(10);
        cmp("R5 level follows pin", filt_level, 0);

        cyc(5);
        done = 1;
        report();
    end
endmodule